// File: doc/BRIEF.md
# Dual-Line Interrupt Level Router

This block sits beside a serial controller that can run either as a plain asynchronous port or as a LIN bus node. It keeps a 32-bit level map with one bit for each interrupt source. A bit of 0 sends that source to the first interrupt line, `int0Out`. A bit of 1 sends it to the second line, `int1Out`. Each line is the registered OR of every source whose flag and enable are both high and whose level bit selects that line.

Software changes the map through two addresses on a simple synchronous register bus. A write to the set address raises each level bit written with 1. A write to the clear address lowers each level bit written with 1. Bits written with 0 are left alone in both cases. A read of either address returns the current map one cycle after the address is presented. The mode input `linMode` decides, bit by bit, which map bits may be written at all.

Source positions in the map:

| Position(s) | Source(s) |
|---|---|
| 0 | break detect |
| 1 | wakeup |
| 4 | timeout |
| 6 | timeout after wakeup |
| 7 | timeout after three wakeups |
| 8 | transmit |
| 9 | receive |
| 13 | ID |
| 24 | parity |
| 25 | overrun |
| 26 | framing |
| 27 | no response |
| 28 | sync field |
| 29 | checksum |
| 30 | physical bus |
| 31 | bit error |

Every other position is unused.

Top module: `int_level_router`

## Requirements
- R1: After reset every level bit is 0, `busRdata` is 0, and both interrupt outputs are 0.
- R2: When `busAddr` equals SET_OFS (0x14) or CLR_OFS (0x18), `busRdata` in the next cycle holds the level map as it was before that edge. Any other address gives 0 in the next cycle.
- R3: A write (`busWe`=1) to SET_OFS sets each writable level bit whose write-data bit is 1. All other level bits keep their value.
- R4: A write to CLR_OFS clears each writable level bit whose write-data bit is 1. All other level bits keep their value.
- R5: Positions 31, 30, 29, 28, 27, 13, 7, 6 and 4 are writable only while `linMode`=1. Set or clear writes to them while `linMode`=0 are ignored.
- R6: Position 0 is writable only while `linMode`=0. Writes to it while `linMode`=1 are ignored.
- R7: Positions 26, 25, 24, 9, 8 and 1 are writable in both modes.
- R8: Unused positions always read as 0 and ignore writes. A flag at an unused position never raises either output.
- R9: `int0Out` becomes 1 one cycle after any used position i has `srcFlag[i]`=1, `srcEn[i]`=1 and level bit 0. Otherwise it becomes 0.
- R10: `int1Out` becomes 1 one cycle after any used position i has `srcFlag[i]`=1, `srcEn[i]`=1 and level bit 1. Otherwise it becomes 0.
- R11: While `busWe`=0 the level map does not change, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| linMode | input | 1 | 1 = LIN operation, 0 = plain asynchronous operation |
| busAddr | input | ADDR_W (8) | Register byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the address |
| srcFlag | input | 32 | Pending interrupt flags, one per map position |
| srcEn | input | 32 | Interrupt enables, one per map position |
| int0Out | output | 1 | Registered OR of enabled pending sources with level 0 |
| int1Out | output | 1 | Registered OR of enabled pending sources with level 1 |

## Verification
The bench writes all-ones to both addresses in each mode. A design with the mode gate inverted or missing would then show LIN-only bits or the break-detect bit changing in the wrong mode. It also drives flags at unused positions with their enables high; a design that forgot to mask them would pulse `int0Out`. Long runs of random addresses, data, flags and mode are compared cycle by cycle with a behavioural model. These runs catch a read or interrupt path that is off by one cycle, and a set or clear that also touches bits written with 0.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  localparam int DATA_W = 32;

  // Map positions writable only in LIN operation
  localparam logic [DATA_W-1:0] LIN_ONLY_MASK = 32'hF800_20D0;
  // Map positions writable only in plain asynchronous operation
  localparam logic [DATA_W-1:0] SCI_ONLY_MASK = 32'h0000_0001;
  // Map positions writable in either mode
  localparam logic [DATA_W-1:0] ANY_MODE_MASK = 32'h0700_0302;
  localparam logic [DATA_W-1:0] USED_MASK = LIN_ONLY_MASK | SCI_ONLY_MASK | ANY_MODE_MASK;

  typedef struct packed {
    logic              setStb;
    logic              clrStb;
    logic              rdSel;
    logic [DATA_W-1:0] wrMask;
  } lvlStb_t;
endpackage

// File: rtl/lvl_ctrl.sv
module lvl_ctrl
  import lvl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h14,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h18
) (
  input  logic              linMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output lvlStb_t           stb
);
  logic hitSet;
  logic hitClr;

  always_comb begin
    hitSet = (busAddr == SET_OFS);
    hitClr = (busAddr == CLR_OFS);
    stb.setStb = busWe && hitSet;
    stb.clrStb = busWe && hitClr;
    stb.rdSel  = hitSet || hitClr;
    stb.wrMask = ANY_MODE_MASK | (linMode ? LIN_ONLY_MASK : SCI_ONLY_MASK);
  end
endmodule

// File: rtl/lvl_datapath.sv
module lvl_datapath
  import lvl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lvlStb_t           stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] srcFlag,
  input  logic [DATA_W-1:0] srcEn,
  output logic [DATA_W-1:0] busRdata,
  output logic              int0Out,
  output logic              int1Out
);
  logic [DATA_W-1:0] levelQ;
  logic [DATA_W-1:0] levelD;
  logic [DATA_W-1:0] wrBits;
  logic [DATA_W-1:0] active;

  always_comb begin
    wrBits = busWdata & stb.wrMask;
    levelD = levelQ;
    if (stb.setStb) levelD = levelD | wrBits;
    if (stb.clrStb) levelD = levelD & ~wrBits;
    active = srcFlag & srcEn & USED_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ   <= '0;
      busRdata <= '0;
      int0Out  <= 1'b0;
      int1Out  <= 1'b0;
    end else begin
      levelQ   <= levelD;
      busRdata <= stb.rdSel ? levelQ : '0;
      int0Out  <= |(active & ~levelQ);
      int1Out  <= |(active & levelQ);
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.setStb && !stb.clrStb) |=> $stable(levelQ)); // R11
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.setStb |=> ((levelQ & $past(busWdata & stb.wrMask)) == $past(busWdata & stb.wrMask))); // R3
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStb |=> ((levelQ & $past(busWdata & stb.wrMask)) == '0)); // R4
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdSel |=> (busRdata == $past(levelQ))); // R2
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & ~USED_MASK) == '0); // R8
endmodule

// File: rtl/int_level_router.sv
module int_level_router
  import lvl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h14,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       srcFlag,
  input  logic [31:0]       srcEn,
  output logic              int0Out,
  output logic              int1Out
);
  lvlStb_t stb;

  lvl_ctrl #(.ADDR_W(ADDR_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)) u_ctrl (
    .linMode (linMode),
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb)
  );

  lvl_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .srcFlag  (srcFlag),
    .srcEn    (srcEn),
    .busRdata (busRdata),
    .int0Out  (int0Out),
    .int1Out  (int1Out)
  );
endmodule

// File: tb/int_level_router_bench.sv
`timescale 1ns/1ps
module int_level_router_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linMode = 1'b1;
  logic [7:0]  busAddr = 8'h00;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] srcFlag = '0;
  logic [31:0] srcEn = '0;
  logic        int0Out;
  logic        int1Out;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_SET = 8'h14;
  localparam logic [7:0] A_CLR = 8'h18;

  int linPos[$] = '{31, 30, 29, 28, 27, 13, 7, 6, 4};
  int sciPos[$] = '{0};
  int anyPos[$] = '{26, 25, 24, 9, 8, 1};

  // behavioural reference state
  bit [31:0] mLevel;
  bit [31:0] expRd;
  bit        expI0, expI1;

  always #10 clk = ~clk;

  int_level_router u_int_level_router (
    .clk(clk), .rstN(rstN), .linMode(linMode), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .srcFlag(srcFlag), .srcEn(srcEn), .int0Out(int0Out), .int1Out(int1Out)
  );

  function automatic void applyBit(int p, bit writable);
    if (writable && busWe && busWdata[p]) begin
      if (busAddr == A_SET) mLevel[p] = 1'b1;
      if (busAddr == A_CLR) mLevel[p] = 1'b0;
    end
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLevel = '0; expRd = '0; expI0 = 1'b0; expI1 = 1'b0;
    end else begin
      expRd = (busAddr == A_SET || busAddr == A_CLR) ? mLevel : 32'h0;
      expI0 = 1'b0; expI1 = 1'b0;
      foreach (linPos[k]) if (srcFlag[linPos[k]] && srcEn[linPos[k]]) begin
        if (mLevel[linPos[k]]) expI1 = 1'b1; else expI0 = 1'b1;
      end
      foreach (sciPos[k]) if (srcFlag[sciPos[k]] && srcEn[sciPos[k]]) begin
        if (mLevel[sciPos[k]]) expI1 = 1'b1; else expI0 = 1'b1;
      end
      foreach (anyPos[k]) if (srcFlag[anyPos[k]] && srcEn[anyPos[k]]) begin
        if (mLevel[anyPos[k]]) expI1 = 1'b1; else expI0 = 1'b1;
      end
      foreach (linPos[k]) applyBit(linPos[k], linMode);
      foreach (sciPos[k]) applyBit(sciPos[k], !linMode);
      foreach (anyPos[k]) applyBit(anyPos[k], 1'b1);
    end
  end

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      check32("R2 model rdata", busRdata, expRd);
      check32("R9 model int0", {31'b0, int0Out}, {31'b0, expI0});
      check32("R10 model int1", {31'b0, int1Out}, {31'b0, expI1});
    end
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic readMap(logic [7:0] a, output logic [31:0] v);
    busAddr = a; busWe = 1'b0;
    @(negedge clk);
    v = busRdata;
  endtask

  task automatic intSample(logic [31:0] f, logic [31:0] e, output logic i0, output logic i1);
    srcFlag = f; srcEn = e;
    @(negedge clk);
    i0 = int0Out; i1 = int1Out;
    srcFlag = '0; srcEn = '0;
  endtask

  initial begin
    logic [31:0] v;
    logic i0, i1;
    #1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check32("R1 rdata", busRdata, 32'h0);
    check32("R1 int0", {31'b0, int0Out}, 32'h0);
    check32("R1 int1", {31'b0, int1Out}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    readMap(A_SET, v); check32("R1 level after reset", v, 32'h0);

    // R3 R5 R7: LIN-mode set of all ones
    linMode = 1'b1;
    busWrite(A_SET, 32'hFFFF_FFFF);
    readMap(A_CLR, v); check32("R3 R5 R7 R8 lin set", v, 32'hFF00_23D2);
    // R4: clear only shared error bits
    busWrite(A_CLR, 32'h0700_0000);
    readMap(A_SET, v); check32("R4 partial clear", v, 32'hF800_23D2);
    // R6: SCI-mode set adds break detect, LIN bits untouched
    linMode = 1'b0;
    busWrite(A_SET, 32'hFFFF_FFFF);
    readMap(A_SET, v); check32("R6 sci set", v, 32'hFF00_23D3);
    // R5: SCI-mode clear leaves LIN-only bits
    busWrite(A_CLR, 32'hFFFF_FFFF);
    readMap(A_SET, v); check32("R5 sci clear", v, 32'hF800_20D0);
    // R11: no write without strobe
    busAddr = A_CLR; busWdata = 32'hFFFF_FFFF; busWe = 1'b0;
    @(negedge clk); busWdata = '0;
    readMap(A_SET, v); check32("R11 no strobe", v, 32'hF800_20D0);
    // R6: LIN-mode set cannot raise break detect; R2 other address reads 0
    linMode = 1'b1;
    busWrite(A_SET, 32'h0000_0001);
    readMap(A_SET, v); check32("R6 lin set bit0", v, 32'hF800_20D0);
    readMap(8'h1C, v); check32("R2 other address", v, 32'h0);
    busWrite(A_CLR, 32'hFFFF_FFFF);
    readMap(A_SET, v); check32("R4 lin clear all", v, 32'h0);

    // R9 R10: routing
    busWrite(A_SET, 32'h0000_0200);
    intSample(32'h0000_0200, 32'h0000_0200, i0, i1);
    check32("R10 rx on int1", {30'b0, i0, i1}, 32'h1);
    intSample(32'h0000_0100, 32'h0000_0100, i0, i1);
    check32("R9 tx on int0", {30'b0, i0, i1}, 32'h2);
    intSample(32'h0000_0300, 32'h0000_0000, i0, i1);
    check32("R9 R10 disabled", {30'b0, i0, i1}, 32'h0);
    // R8: unused positions ignored
    intSample(32'h00FF_1C2C, 32'hFFFF_FFFF, i0, i1);
    check32("R8 unused flags", {30'b0, i0, i1}, 32'h0);
    busWrite(A_CLR, 32'hFFFF_FFFF);

    // random traffic checked by the model every cycle
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = $urandom_range(0, 3);
      busAddr = (sel == 0) ? A_SET : (sel == 1) ? A_CLR : (sel == 2) ? 8'($urandom) : A_SET;
      busWe = $urandom_range(0, 2) != 0;
      busWdata = $urandom;
      srcFlag = $urandom;
      srcEn = $urandom;
      if ($urandom_range(0, 15) == 0) linMode = ~linMode;
      @(negedge clk);
    end
    busWe = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule